// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Commit

This block sits behind a CAN frame assembly stage. Each time that stage presents a complete frame (identifier, extended and remote flags, length code and the first two data bytes) for one clock cycle, the block compares the frame against two programmable acceptance banks. Bank 0 holds one mask and two filters and feeds receive buffer 0. Bank 1 holds one mask and four filters and feeds receive buffer 1. An accepted frame is copied into its buffer together with a code naming the filter that accepted it, and the buffer's full flag is set.

A full buffer keeps its contents until the host clears it. A frame aimed at a full buffer raises a one-cycle overflow pulse and is discarded. Buffer 0 wins when both banks accept the same frame, and with rollover enabled a frame accepted by bank 0 while buffer 0 is full goes to buffer 1 instead. For standard data frames the low 16 bits of each mask and filter compare the first two data bytes, so filtering can extend into the payload. Masks and filters can only be written while the configuration input is high, and no frames are taken in that state.

Top module: `can_rx_accept`

## Requirements
- R1: After reset both full flags and both overflow pulses are 0, and all masks and filters are 0.
- R2: A filter matches when every identifier bit whose mask bit is 1 equals the filter bit; mask bits of 0 are don't-care. The stored hit code is the lowest-numbered matching filter of the accepting bank (codes 0 to 5).
- R3: The compared 29-bit vector is the identifier for extended frames. For standard frames it is the 11-bit identifier in bits [28:18], zeros in [17:16], the first data byte in [15:8] and the second in [7:0]; a byte that is absent (remote frame, or length code below 1 or 2) counts as zero.
- R4: Each filter has an extended-enable bit that must equal the frame's extended flag for a match.
- R5: Filters 0 and 1 with mask 0 feed buffer 0; filters 2 to 5 with mask 1 feed buffer 1; when both banks accept, buffer 0 is chosen.
- R6: A bank mode input of 2'b11 accepts every frame for that bank and stores hit code 7.
- R7: With rollover enabled, a frame accepted by bank 0 while buffer 0 is full is stored in buffer 1 (if empty) with its bank-0 hit code.
- R8: A frame whose destination buffer is full gives a one-cycle overflow pulse for that buffer in the cycle after the frame, and leaves that buffer's contents and flag unchanged.
- R9: A clear input empties its buffer at the next edge; a frame arriving in the same cycle as the clear still sees the buffer full and overflows.
- R10: Mask and filter writes take effect only while the configuration input is high; frames presented while it is high are not stored.
- R11: A stored buffer holds the identifier, extended flag, remote flag, length code and both data bytes exactly as received, visible in the cycle after the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | Configuration state: enables writes, blocks frames |
| cfg_we | input | 1 | Mask/filter write strobe |
| cfg_addr | input | 3 | 0..5 filter index, 6 mask 0, 7 mask 1 |
| cfg_val | input | 29 | Value written |
| cfg_ext | input | 1 | Extended-enable bit for a filter write |
| mode0 | input | 2 | Bank 0 mode, 2'b11 accepts all |
| mode1 | input | 2 | Bank 1 mode, 2'b11 accepts all |
| roll_en | input | 1 | Rollover from buffer 0 to buffer 1 |
| frm_valid | input | 1 | Complete frame present this cycle |
| frm_id | input | 29 | Identifier, standard in [28:18] |
| frm_ext | input | 1 | Extended frame |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Length code |
| frm_d0 | input | 8 | First data byte |
| frm_d1 | input | 8 | Second data byte |
| clr0 | input | 1 | Empty buffer 0 |
| clr1 | input | 1 | Empty buffer 1 |
| full0 | output | 1 | Buffer 0 holds a frame |
| full1 | output | 1 | Buffer 1 holds a frame |
| ovf0 | output | 1 | Overflow pulse, buffer 0 |
| ovf1 | output | 1 | Overflow pulse, buffer 1 |
| b0_id | output | 29 | Buffer 0 identifier |
| b0_ext | output | 1 | Buffer 0 extended flag |
| b0_rtr | output | 1 | Buffer 0 remote flag |
| b0_dlc | output | 4 | Buffer 0 length code |
| b0_data | output | 16 | Buffer 0 bytes, first in [15:8] |
| b0_hit | output | 3 | Buffer 0 hit code |
| b1_id | output | 29 | Buffer 1 identifier |
| b1_ext | output | 1 | Buffer 1 extended flag |
| b1_rtr | output | 1 | Buffer 1 remote flag |
| b1_dlc | output | 4 | Buffer 1 length code |
| b1_data | output | 16 | Buffer 1 bytes, first in [15:8] |
| b1_hit | output | 3 | Buffer 1 hit code |

## Verification
The host clear of a buffer and the arrival of a frame aimed at that same full buffer can fall in one cycle. The bench fills buffer 0 with rollover off, then raises the clear and the frame valid in the same cycle. It expects an overflow pulse on buffer 0, the original contents kept, and the full flag low afterwards, which shows the decision used the flag as it stood before the clear.

// File: rtl/can_rx_accept.sv
module can_rx_accept (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_mode,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [28:0] cfg_val,
  input  logic        cfg_ext,
  input  logic [1:0]  mode0,
  input  logic [1:0]  mode1,
  input  logic        roll_en,
  input  logic        frm_valid,
  input  logic [28:0] frm_id,
  input  logic        frm_ext,
  input  logic        frm_rtr,
  input  logic [3:0]  frm_dlc,
  input  logic [7:0]  frm_d0,
  input  logic [7:0]  frm_d1,
  input  logic        clr0,
  input  logic        clr1,
  output logic        full0,
  output logic        full1,
  output logic        ovf0,
  output logic        ovf1,
  output logic [28:0] b0_id,
  output logic        b0_ext,
  output logic        b0_rtr,
  output logic [3:0]  b0_dlc,
  output logic [15:0] b0_data,
  output logic [2:0]  b0_hit,
  output logic [28:0] b1_id,
  output logic        b1_ext,
  output logic        b1_rtr,
  output logic [3:0]  b1_dlc,
  output logic [15:0] b1_data,
  output logic [2:0]  b1_hit
);

  localparam int NFLT = 6;
  localparam logic [2:0] HIT_ANY = 3'd7;

  logic [28:0] flt [NFLT];
  logic [NFLT-1:0] fext;
  logic [28:0] msk0, msk1;

  wire [7:0]  db0 = (frm_rtr || frm_dlc == 4'd0) ? 8'h00 : frm_d0;
  wire [7:0]  db1 = (frm_rtr || frm_dlc < 4'd2) ? 8'h00 : frm_d1;
  wire [28:0] cmp = frm_ext ? frm_id : {frm_id[28:18], 2'b00, db0, db1};

  logic [NFLT-1:0] hit;
  for (genvar i = 0; i < NFLT; i++) begin : g_flt
    wire [28:0] m = (i < 2) ? msk0 : msk1;
    assign hit[i] = (((cmp ^ flt[i]) & m) == 29'd0) && (fext[i] == frm_ext);
  end

  wire any0 = (mode0 == 2'b11);
  wire any1 = (mode1 == 2'b11);
  wire acc0 = any0 || (|hit[1:0]);
  wire acc1 = any1 || (|hit[5:2]);

  wire [2:0] code0 = any0 ? HIT_ANY : (hit[0] ? 3'd0 : 3'd1);
  wire [2:0] code1 = any1 ? HIT_ANY :
                     hit[2] ? 3'd2 : hit[3] ? 3'd3 : hit[4] ? 3'd4 : 3'd5;

  wire take  = frm_valid && !cfg_mode;
  wire roll  = acc0 && full0 && roll_en;
  wire to0   = take && acc0 && !roll;
  wire to1   = take && (roll || (!acc0 && acc1));
  wire st0   = to0 && !full0;
  wire st1   = to1 && !full1;
  wire [2:0] code1_sel = roll ? code0 : code1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLT; i++) flt[i] <= '0;
      fext <= '0;
      msk0 <= '0;
      msk1 <= '0;
    end else if (cfg_mode && cfg_we) begin
      case (cfg_addr)
        3'd6: msk0 <= cfg_val;
        3'd7: msk1 <= cfg_val;
        default: begin
          flt[cfg_addr]  <= cfg_val;
          fext[cfg_addr] <= cfg_ext;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full0 <= 1'b0; full1 <= 1'b0; ovf0 <= 1'b0; ovf1 <= 1'b0;
      b0_id <= '0; b0_ext <= 1'b0; b0_rtr <= 1'b0; b0_dlc <= '0; b0_data <= '0; b0_hit <= '0;
      b1_id <= '0; b1_ext <= 1'b0; b1_rtr <= 1'b0; b1_dlc <= '0; b1_data <= '0; b1_hit <= '0;
    end else begin
      ovf0 <= to0 && full0;
      ovf1 <= to1 && full1;
      if (st0) begin
        full0 <= 1'b1;
        b0_id <= frm_id; b0_ext <= frm_ext; b0_rtr <= frm_rtr;
        b0_dlc <= frm_dlc; b0_data <= {frm_d0, frm_d1}; b0_hit <= code0;
      end else if (clr0) begin
        full0 <= 1'b0;
      end
      if (st1) begin
        full1 <= 1'b1;
        b1_id <= frm_id; b1_ext <= frm_ext; b1_rtr <= frm_rtr;
        b1_dlc <= frm_dlc; b1_data <= {frm_d0, frm_d1}; b1_hit <= code1_sel;
      end else if (clr1) begin
        full1 <= 1'b0;
      end
    end
  end

  // R1
  initial begin
    #1;
    if (!rst_n) reset_flags_chk: assert (!full0 && !full1 && !ovf0 && !ovf1);
  end

  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(msk0) && $stable(msk1) && $stable(fext));

  // R10
  cfg_nofrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && !full0 && !full1) |=> (!full0 && !full1));

  // R8
  ovf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf0, ovf1}));

  // R8
  ovf0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full0 && !clr0) |=> (full0 && $stable(b0_id) && $stable(b0_data) && $stable(b0_hit)));

  // R8
  ovf1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full1 && !clr1) |=> (full1 && $stable(b1_id) && $stable(b1_data) && $stable(b1_hit)));

  // R9
  clr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full0 && clr0) |=> !full0);

  // R5
  fill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full0) || $rose(full1)) |-> $past(frm_valid && !cfg_mode));

endmodule

// File: tb/sim_can_rx_accept.sv
module sim_can_rx_accept;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 0, cfg_we = 0, cfg_ext = 0, roll_en = 0;
  logic [2:0] cfg_addr = 0;
  logic [28:0] cfg_val = 0;
  logic [1:0] mode0 = 0, mode1 = 0;
  logic frm_valid = 0, frm_ext = 0, frm_rtr = 0, clr0 = 0, clr1 = 0;
  logic [28:0] frm_id = 0;
  logic [3:0] frm_dlc = 0;
  logic [7:0] frm_d0 = 0, frm_d1 = 0;
  logic full0, full1, ovf0, ovf1, b0_ext, b0_rtr, b1_ext, b1_rtr;
  logic [28:0] b0_id, b1_id;
  logic [3:0] b0_dlc, b1_dlc;
  logic [15:0] b0_data, b1_data;
  logic [2:0] b0_hit, b1_hit;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  can_rx_accept u0 (.*);

  localparam logic [28:0] EXT_A = 29'h1ABCDEF0;

  function automatic logic [28:0] sid(input logic [10:0] s, input logic [7:0] a, input logic [7:0] b);
    return {s, 2'b00, a, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [28:0] v, input logic e);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_val = v; cfg_ext = e;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // frame held for one cycle; outputs sampled at the following negedge
  task automatic send(input logic [10:0] s, input logic [28:0] xid, input logic e, input logic r,
                      input logic [3:0] dlc, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    frm_valid = 1; frm_ext = e; frm_rtr = r; frm_dlc = dlc; frm_d0 = a; frm_d1 = b;
    frm_id = e ? xid : {s, 18'h0};
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic clear(input logic c0, input logic c1);
    @(negedge clk);
    clr0 = c0; clr1 = c1;
    @(negedge clk);
    clr0 = 0; clr1 = 0;
  endtask

  task automatic t_reset;
    chk("R1 full0", full0, 0); chk("R1 full1", full1, 0);
    chk("R1 ovf", {ovf0, ovf1}, 0);
  endtask

  task automatic t_config;
    cfg_mode = 1;
    wr(6, {11'h7FF, 18'h3FFFF}, 0);
    wr(0, sid(11'h123, 8'h00, 8'h00), 0);
    wr(1, sid(11'h456, 8'hAA, 8'h55), 0);
    wr(7, {11'h7FF, 18'h0}, 0);
    wr(2, sid(11'h100, 8'h00, 8'h00), 0);
    wr(3, EXT_A, 1);
    wr(4, sid(11'h300, 8'h00, 8'h00), 0);
    wr(5, sid(11'h200, 8'h00, 8'h00), 0);
    send(11'h123, 0, 0, 0, 4'd2, 8'h00, 8'h00);
    chk("R10 frame ignored in config", {full0, full1}, 0);
    cfg_mode = 0;
    wr(6, 29'h0, 0);
  endtask

  task automatic t_basic;
    send(11'h123, 0, 0, 0, 4'd2, 8'h00, 8'h00);
    chk("R2 full0", full0, 1); chk("R2 hit0", b0_hit, 0);
    chk("R11 id", b0_id, {11'h123, 18'h0}); chk("R11 dlc", b0_dlc, 2);
    chk("R5 full1 idle", full1, 0);
    clear(1, 0);
    chk("R9 cleared", full0, 0);
    send(11'h456, 0, 0, 0, 4'd8, 8'hAA, 8'h55);
    chk("R3 data match", full0, 1); chk("R3 hit1", b0_hit, 1);
    chk("R11 data", b0_data, 16'hAA55); chk("R11 rtr", b0_rtr, 0);
    clear(1, 0);
    send(11'h456, 0, 0, 0, 4'd8, 8'hAA, 8'h54);
    chk("R10 mask write blocked / R3 byte miss", {full0, full1}, 0);
    send(11'h456, 0, 0, 1, 4'd8, 8'hAA, 8'h55);
    chk("R3 remote bytes zero", {full0, full1}, 0);
    send(11'h456, 0, 0, 0, 4'd1, 8'hAA, 8'h55);
    chk("R3 short dlc", {full0, full1}, 0);
  endtask

  task automatic t_ext;
    send(0, {11'h100, 18'h0}, 1, 0, 4'd3, 8'h11, 8'h22);
    chk("R4 ext vs std filter", {full0, full1}, 0);
    send(0, EXT_A, 1, 0, 4'd3, 8'h11, 8'h22);
    chk("R5 buf1", full1, 1); chk("R2 hit3", b1_hit, 3);
    chk("R11 ext", b1_ext, 1); chk("R11 id1", b1_id, EXT_A);
    send(0, EXT_A, 1, 0, 4'd5, 8'h33, 8'h44);
    chk("R8 ovf1", ovf1, 1); chk("R8 keep dlc", b1_dlc, 3);
    @(negedge clk);
    chk("R8 pulse one cycle", ovf1, 0);
    send(11'h300, 0, 0, 0, 4'd0, 8'h00, 8'h00);
    chk("R2 lowest match ovf", ovf1, 1);
    clear(0, 1);
    send(11'h300, 0, 0, 0, 4'd0, 8'h00, 8'h00);
    chk("R2 hit4", b1_hit, 4);
    clear(0, 1);
  endtask

  task automatic t_roll;
    send(11'h123, 0, 0, 0, 4'd4, 8'h00, 8'h00);
    send(11'h123, 0, 0, 0, 4'd6, 8'h00, 8'h00);
    chk("R8 ovf0", ovf0, 1); chk("R8 keep buf0", b0_dlc, 4);
    chk("R7 no roll", full1, 0);
    roll_en = 1;
    send(11'h123, 0, 0, 0, 4'd7, 8'h00, 8'h00);
    chk("R7 rolled", full1, 1); chk("R7 hit", b1_hit, 0);
    chk("R7 dlc", b1_dlc, 7); chk("R7 no ovf0", ovf0, 0);
    send(11'h123, 0, 0, 0, 4'd1, 8'h00, 8'h00);
    chk("R7 both full ovf1", {ovf0, ovf1}, 2'b01);
    roll_en = 0;
    clear(1, 1);
  endtask

  task automatic t_modes;
    mode0 = 2'b11;
    send(11'h100, 0, 0, 0, 4'd0, 8'h00, 8'h00);
    chk("R6 any buf0", full0, 1); chk("R6 hit7", b0_hit, 7);
    chk("R5 priority", full1, 0);
    mode0 = 2'b00; mode1 = 2'b11;
    send(11'h555, 0, 0, 0, 4'd0, 8'h00, 8'h00);
    chk("R6 any buf1", full1, 1); chk("R6 hit7 b1", b1_hit, 7);
    mode1 = 2'b00;
    clear(0, 1);
  endtask

  task automatic t_clr_race;
    @(negedge clk);
    clr0 = 1; frm_valid = 1; frm_ext = 0; frm_rtr = 0; frm_dlc = 4'd9; frm_id = {11'h123, 18'h0};
    @(negedge clk);
    clr0 = 0; frm_valid = 0;
    chk("R9 race ovf0", ovf0, 1); chk("R9 race cleared", full0, 0);
    chk("R9 race kept", b0_dlc, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    t_reset;
    #10 rst_n = 1;
    t_config;
    t_basic;
    t_ext;
    t_roll;
    t_modes;
    t_clr_race;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule